// File: doc/BRIEF.md
# CEC Signal Free Time Timer

This block holds off a local transmission on a single-wire CEC bus until the line has been idle for a programmed number of half bit periods. It counts a fixed-rate timing tick while the sampled bus level is high, and it raises a `bus_free` flag once the programmed idle time has passed. A start request that software makes before the bus is free is held back. It is released as a one-cycle `tx_start` pulse once the flag is high.

The idle time comes from a 3-bit code. A second configuration bit chooses what starts the idle count. With the bit at 0, the software start request starts the count. With the bit at 1, the end of any transmitted or received message starts it. Both configuration inputs are captured only while the controller enable is low. The nominal bit period is 2.4 ms and the tick is 0.1 ms, so a half bit period is 12 ticks.

Top module: `cec_sft_timer`

## Requirements
- R1: After reset, `bus_free` and `tx_start` are both 0.
- R2: The idle threshold in ticks is (2*code-1)*12 for a captured code of 1 to 7, and 60 for code 0. `bus_free` goes high on the clock edge that samples the tick completing the threshold. It is low after the tick before that one.
- R3: When `cfg_auto_start`=0, a `tx_req` pulse clears `bus_free` and restarts the count from zero. `tx_eom` and `rx_eom` do not start a count.
- R4: When `cfg_auto_start`=1, a `tx_eom` or `rx_eom` pulse clears `bus_free` and restarts the count from zero. `tx_req` does not start a count.
- R5: A low `bus_level` during counting resets the count to zero, and ticks seen while the line is low are not counted. Counting resumes from zero once the line is high again, so `bus_free` can only rise after a tick sampled with the line high.
- R6: Once high, `bus_free` stays high until a `tx_start` pulse is issued, a low `bus_level` is sampled, or a new count is started. In each case it is low after the next edge.
- R7: A `tx_req` is held pending until `bus_free` is high. `tx_start` is then high for exactly one cycle. When `bus_free` rises with a request pending, `tx_start` is high in that same cycle. When a request arrives with `bus_free` already high, `tx_start` is high in the cycle after the request.
- R8: The code and the option bit are captured only while `ctl_en`=0. Changes made to them while `ctl_en`=1 have no effect.
- R9: While `ctl_en`=0, `bus_free` is low after the next edge. Any pending request and any count in progress are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Controller enable; configuration is captured while low |
| cfg_sft_code | input | 3 | Idle time code (0 means default of 5 half bits) |
| cfg_auto_start | input | 1 | 0: count starts on request; 1: count starts at end of message |
| tx_req | input | 1 | Software start-of-message strobe |
| tx_eom | input | 1 | End of transmitted message pulse |
| rx_eom | input | 1 | End of received message pulse |
| bus_level | input | 1 | Sampled CEC line level, 1 = released/high |
| tick | input | 1 | One-cycle timing tick, one every 0.1 ms |
| bus_free | output | 1 | Bus has been idle for the programmed time |
| tx_start | output | 1 | One-cycle pulse launching a held request |

## Verification
Every input acts at the next rising edge, and both outputs follow after one register stage. `bus_free` therefore changes at the edge that samples the final tick, a trigger or a low line. `tx_start` is high in the cycle in which `bus_free` and a pending request are both high. The bench drives each stimulus for exactly one cycle, starting at a falling edge, and reads the outputs at the following falling edge. Threshold checks look one tick early (expect low) and at the exact tick (expect high). Release checks then look one cycle later (expect both low).

// File: rtl/cec_sft_pkg.sv
// Package: shared constants for the CEC idle-time timer.
// Assumes a 0.1 ms tick and a 2.4 ms nominal bit period.
package cec_sft_pkg;
    localparam int SFT_CODE_W        = 3;
    localparam int SFT_TICKS_PER_HALF = 12;
    localparam int SFT_DEFAULT_HALVES = 5;
endpackage

// File: rtl/cec_sft_cfg.sv
// Module: cec_sft_cfg
// Captures the idle-time code and start option while the controller is
// disabled, and decodes the code into a tick threshold.
// Assumes ctl_en is synchronous to clk.
module cec_sft_cfg #(
    parameter int CODE_W         = cec_sft_pkg::SFT_CODE_W,
    parameter int TICKS_PER_HALF = cec_sft_pkg::SFT_TICKS_PER_HALF,
    parameter int DEFAULT_HALVES = cec_sft_pkg::SFT_DEFAULT_HALVES,
    parameter int CNT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_auto,
    output logic [CODE_W-1:0] code_q,
    output logic              auto_q,
    output logic [CNT_W-1:0]  thr_ticks
);
    int halves;

    // Capture configuration only while the controller is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            auto_q <= 1'b0;
        end else if (!ctl_en) begin
            code_q <= cfg_code;
            auto_q <= cfg_auto;
        end
    end

    // Decode the captured code into a number of ticks.
    always_comb begin
        if (code_q == '0) halves = DEFAULT_HALVES;
        else              halves = 2 * int'(code_q) - 1;
        thr_ticks = CNT_W'(halves * TICKS_PER_HALF);
    end
endmodule

// File: rtl/cec_sft_idle_cnt.sv
// Module: cec_sft_idle_cnt
// Counts ticks of high bus level after an arm event and raises the free
// flag at the threshold; clears on activity, launch or disable.
// Assumes arm and start_fire are single-cycle pulses.
module cec_sft_idle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             arm,
    input  logic             start_fire,
    input  logic             bus_level,
    input  logic             tick,
    input  logic [CNT_W-1:0] thr_ticks,
    output logic             free_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next count value.
    assign cnt_inc = cnt_q + 1'b1;

    // Idle counter with free-flag hold and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            free_q <= 1'b0;
        end else if (arm) begin
            cnt_q  <= '0;
            run_q  <= 1'b1;
            free_q <= 1'b0;
        end else if (free_q) begin
            if (!bus_level || start_fire) free_q <= 1'b0;
        end else if (run_q) begin
            if (!bus_level) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_inc == thr_ticks) begin
                    cnt_q  <= '0;
                    run_q  <= 1'b0;
                    free_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end
endmodule

// File: rtl/cec_sft_start_gate.sv
// Module: cec_sft_start_gate
// Holds a software start request until the bus is free, then issues one
// launch pulse. Assumes free is registered upstream.
module cec_sft_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_en,
    input  logic req,
    input  logic free,
    output logic start
);
    logic pend_q;

    // Launch when a request is pending and the bus is free.
    assign start = pend_q & free;

    // Pending request flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) pend_q <= 1'b0;
        else if (start)        pend_q <= 1'b0;
        else if (req)          pend_q <= 1'b1;
    end
endmodule

// File: rtl/cec_sft_timer.sv
// Module: cec_sft_timer (top)
// Enforces the minimum idle time on a CEC line before a local transmission.
// Assumes all inputs are synchronous to clk and tick is one cycle wide.
module cec_sft_timer #(
    parameter int CODE_W         = cec_sft_pkg::SFT_CODE_W,
    parameter int TICKS_PER_HALF = cec_sft_pkg::SFT_TICKS_PER_HALF,
    parameter int DEFAULT_HALVES = cec_sft_pkg::SFT_DEFAULT_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic [CODE_W-1:0] cfg_sft_code,
    input  logic              cfg_auto_start,
    input  logic              tx_req,
    input  logic              tx_eom,
    input  logic              rx_eom,
    input  logic              bus_level,
    input  logic              tick,
    output logic              bus_free,
    output logic              tx_start
);
    localparam int MAX_HALVES = 2 * (2 ** CODE_W) - 3;
    localparam int MAX_TICKS  = (MAX_HALVES > DEFAULT_HALVES ? MAX_HALVES : DEFAULT_HALVES)
                                * TICKS_PER_HALF;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    logic [CODE_W-1:0] code_q;
    logic              opt_q;
    logic [CNT_W-1:0]  thr_ticks;
    logic              arm;

    cec_sft_cfg #(
        .CODE_W(CODE_W), .TICKS_PER_HALF(TICKS_PER_HALF),
        .DEFAULT_HALVES(DEFAULT_HALVES), .CNT_W(CNT_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
        .cfg_code(cfg_sft_code), .cfg_auto(cfg_auto_start),
        .code_q(code_q), .auto_q(opt_q), .thr_ticks(thr_ticks)
    );

    // Select the trigger that starts an idle count.
    assign arm = opt_q ? (tx_eom | rx_eom) : tx_req;

    cec_sft_idle_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .arm(arm),
        .start_fire(tx_start), .bus_level(bus_level), .tick(tick),
        .thr_ticks(thr_ticks), .free_q(bus_free)
    );

    cec_sft_start_gate gate_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .req(tx_req),
        .free(bus_free), .start(tx_start)
    );
endmodule

// File: rtl/cec_sft_timer_chk.sv
// Module: cec_sft_timer_chk
// Temporal properties of the idle-time timer, bound to the top module.
module cec_sft_timer_chk #(
    parameter int CODE_W = cec_sft_pkg::SFT_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              bus_level,
    input logic              tick,
    input logic              bus_free,
    input logic              tx_start,
    input logic [CODE_W-1:0] code_q,
    input logic              opt_q
);
    AST_FREE_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(tick)); // R2
    AST_FREE_RISES_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(bus_level)); // R5
    AST_LOW_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && !bus_level) |=> !bus_free); // R6
    AST_START_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !bus_free); // R6
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && ctl_en) |-> ($stable(code_q) && $stable(opt_q))); // R8
    AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (!bus_free && !tx_start)); // R9
endmodule

bind cec_sft_timer cec_sft_timer_chk #(.CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .bus_level(bus_level),
    .tick(tick), .bus_free(bus_free), .tx_start(tx_start),
    .code_q(code_q), .opt_q(opt_q)
);

// File: tb/cec_sft_timer_tb_top.sv
// Bench: sweeps every idle code under both start options and checks the
// threshold, hold, release, line-activity and configuration behaviour.
module cec_sft_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_en = 1'b0;
    logic [2:0] cfg_sft_code = '0;
    logic       cfg_auto_start = 1'b0;
    logic       tx_req = 1'b0, tx_eom = 1'b0, rx_eom = 1'b0;
    logic       bus_level = 1'b1, tick = 1'b0;
    logic       bus_free, tx_start;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cec_sft_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cfg_sft_code(cfg_sft_code),
        .cfg_auto_start(cfg_auto_start), .tx_req(tx_req), .tx_eom(tx_eom),
        .rx_eom(rx_eom), .bus_level(bus_level), .tick(tick),
        .bus_free(bus_free), .tx_start(tx_start)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int thr_of(input int code);
        return (code == 0) ? 60 : (2 * code - 1) * 12;
    endfunction

    task automatic configure(input int code, input logic opt);
        @(negedge clk);
        ctl_en = 1'b0; cfg_sft_code = 3'(code); cfg_auto_start = opt;
        @(negedge clk); @(negedge clk);
        ctl_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        if (which == 0) tx_req = 1'b1;
        else if (which == 1) tx_eom = 1'b1;
        else rx_eom = 1'b1;
        @(negedge clk);
        tx_req = 1'b0; tx_eom = 1'b0; rx_eom = 1'b0;
    endtask

    task automatic ticks(input int k);
        if (k > 0) begin
            tick = 1'b1;
            repeat (k) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 free", bus_free, 1'b0);
        check("R1 start", tx_start, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 free after release", bus_free, 1'b0);

        // Request-started sweep (R2, R3, R7, R6).
        for (int c = 0; c < 8; c++) begin
            configure(c, 1'b0);
            pulse(0);
            ticks(thr_of(c) - 1);
            check("R2 opt0 early", bus_free, 1'b0);
            ticks(1);
            check("R2 opt0 exact", bus_free, 1'b1);
            check("R7 release on rise", tx_start, 1'b1);
            @(negedge clk);
            check("R6 free cleared by start", bus_free, 1'b0);
            check("R7 single pulse", tx_start, 1'b0);
        end
        configure(1, 1'b0);
        pulse(1);
        pulse(2);
        ticks(14);
        check("R3 eom ignored", bus_free, 1'b0);

        // Message-end-started sweep (R2, R4, R6, R7).
        for (int c = 0; c < 8; c++) begin
            configure(c, 1'b1);
            pulse((c % 2 == 1) ? 2 : 1);
            ticks(thr_of(c) - 1);
            check("R2 opt1 early", bus_free, 1'b0);
            ticks(1);
            check("R2 opt1 exact", bus_free, 1'b1);
            check("R7 nothing pending", tx_start, 1'b0);
            ticks(5);
            check("R6 held", bus_free, 1'b1);
            pulse(0);
            check("R7 request while free", tx_start, 1'b1);
            @(negedge clk);
            check("R6 cleared after start", bus_free, 1'b0);
            check("R7 one cycle", tx_start, 1'b0);
        end
        pulse(0);
        ticks(14);
        check("R4 request does not arm", bus_free, 1'b0);

        // Pending request held until free (R7).
        configure(1, 1'b1);
        pulse(1);
        ticks(3);
        pulse(0);
        check("R7 held while busy", tx_start, 1'b0);
        ticks(8);
        check("R7 still held", tx_start, 1'b0);
        ticks(1);
        check("R7 pending free", bus_free, 1'b1);
        check("R7 pending launch", tx_start, 1'b1);
        @(negedge clk);
        check("R7 pending one cycle", tx_start, 1'b0);

        // Line activity restarts the count (R5) and clears free (R6).
        pulse(2);
        ticks(5);
        bus_level = 1'b0; tick = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_level = 1'b1; tick = 1'b0;
        @(negedge clk);
        ticks(11);
        check("R5 restarted early", bus_free, 1'b0);
        ticks(1);
        check("R5 restarted exact", bus_free, 1'b1);
        bus_level = 1'b0;
        @(negedge clk);
        bus_level = 1'b1;
        check("R6 low line clears", bus_free, 1'b0);

        // Configuration frozen while enabled (R8).
        configure(1, 1'b1);
        cfg_sft_code = 3'd7; cfg_auto_start = 1'b0;
        pulse(1);
        ticks(11);
        check("R8 early", bus_free, 1'b0);
        ticks(1);
        check("R8 old code kept", bus_free, 1'b1);

        // Disable clears state (R9).
        ctl_en = 1'b0;
        @(negedge clk);
        check("R9 free dropped", bus_free, 1'b0);
        configure(1, 1'b1);
        pulse(1);
        pulse(0);
        ctl_en = 1'b0;
        @(negedge clk);
        ctl_en = 1'b1;
        @(negedge clk);
        pulse(1);
        ticks(12);
        check("R9 free after re-enable", bus_free, 1'b1);
        check("R9 pending discarded", tx_start, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule